// File: doc/BRIEF.md
# Host Control Register with Interrupt Gating

This block holds a 32-bit control word that a host reads and writes through a plain register port. Its upper half is a fixed revision number. Its lower half holds control bits. Some of these bits only enable features elsewhere in the chip. Others act inside the block.

The block keeps an internal interrupt-pending flag. An event pulse sets the flag and only an explicit clear pulse resets it. The flag drives an active-low level interrupt pin through two masks that behave differently:

- **Pin mask (bit 8):** forces the pin inactive while the flag is kept.
- **Output mask (bit 1):** only stops new assertions. A pin that is already low stays low.

Bits 4 and 5 grant write permission to two neighbouring registers. Bits 2 and 3 select byte and halfword swapping on a 32-bit target data path.

Top module: `hostctl_reg`

## Requirements
- R1: Bits 31:16 of `reg_rdata` always read the parameter `REV_ID`, and writes to them have no effect.
- R2: After reset, bits 15:0 of `reg_rdata` and `opt_en` read 0, `irq_n` is 1, and both write-permission outputs are 0.
- R3: A write stores `reg_wdata[15:1]`, and the stored value is visible on `reg_rdata[15:0]` and `opt_en` in the cycle after the write edge. Bit 0 is reserved: it always reads 0.
- R4: An event pulse sampled at clock edge k sets the pending flag. With both masks clear, `irq_n` goes low after edge k+1. A clear pulse drops the flag, and `irq_n` returns high one edge later. When the event and the clear arrive in the same cycle, the clear wins.
- R5: While bit 8 is set, `irq_n` is 1 from the edge after the write onward, and the pending flag is kept. Clearing bit 8 with the flag still set brings `irq_n` low one edge after that write.
- R6: Setting bit 1 while `irq_n` is low leaves `irq_n` low.
- R7: While bit 1 is set and the pin was not already presented, new events leave `irq_n` high. Clearing bit 1 with the flag still set brings `irq_n` low one edge after that write. If the flag was cleared meanwhile, `irq_n` stays high.
- R8: `aux_we_a` equals stored bit 4 and `aux_we_b` equals stored bit 5, so each neighbour is read-only while its bit is 0.
- R9: `swp_dout` is `swp_din` passed through two stages:
  - first, with bit 2 set, the four bytes are reversed;
  - then, with bit 3 set, the upper and lower 16-bit halves of that result are exchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| evt_i | input | 1 | Interrupt event pulse |
| clr_i | input | 1 | Pending-flag clear pulse |
| irq_n | output | 1 | Active-low level interrupt pin |
| aux_we_a | output | 1 | Write permission for the first neighbour register |
| aux_we_b | output | 1 | Write permission for the second neighbour register |
| opt_en | output | 16 | Stored control bits, bit 0 reads 0 |
| swp_din | input | 32 | Target path data in |
| swp_dout | output | 32 | Target path data out, swapped |

## Verification
The swap path is swept over all four mode settings with eight data words that have distinct bytes, so a wrong byte order or a wrong stage order shows up as a distinct mismatch. The interrupt logic is tried with every combination of the two masks set before an event, and with each mask set after the pin is already low. This separates the immediate drop caused by bit 8 from the assertion-only blocking of bit 1. Sequences that clear the flag while it is held back show whether a blocked event is replayed only while still pending. A same-cycle event and clear shows which of the two wins.

// File: rtl/hostctl_reg.sv
module hostctl_reg #(
  parameter logic [15:0] REV_ID = 16'h5A21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        evt_i,
  input  logic        clr_i,
  output logic        irq_n,
  output logic        aux_we_a,
  output logic        aux_we_b,
  output logic [15:0] opt_en,
  input  logic [31:0] swp_din,
  output logic [31:0] swp_dout
);
  logic [15:1] ctl_q;
  logic        pend_q, shown_q, pin_q;
  logic        shown_d;
  logic [31:0] bsw;

  // presented state survives the output mask once shown
  assign shown_d = pend_q & (shown_q | ~ctl_q[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      pend_q  <= 1'b0;
      shown_q <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      if (reg_we) ctl_q <= reg_wdata[15:1];
      pend_q  <= ~clr_i & (pend_q | evt_i);
      shown_q <= shown_d;
      pin_q   <= shown_d & ~ctl_q[8];
    end
  end

  assign irq_n     = ~pin_q;
  assign opt_en    = {ctl_q, 1'b0};
  assign reg_rdata = {REV_ID, ctl_q, 1'b0};
  assign aux_we_a  = ctl_q[4];
  assign aux_we_b  = ctl_q[5];

  assign bsw      = ctl_q[2] ? {swp_din[7:0], swp_din[15:8], swp_din[23:16], swp_din[31:24]} : swp_din;
  assign swp_dout = ctl_q[3] ? {bsw[15:0], bsw[31:16]} : bsw;
endmodule

module hostctl_reg_chk #(
  parameter logic [15:0] REV_ID = 16'h5A21
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [31:0] reg_rdata,
  input logic        clr_i,
  input logic        irq_n,
  input logic [15:0] opt_en,
  input logic [31:0] swp_din,
  input logic [31:0] swp_dout
);
  a_r1_rev_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:16] == REV_ID);

  a_r3_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[0] == 1'b0);

  a_r5_pin_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $past(opt_en[8]) |-> irq_n);

  a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !$past(clr_i) && !$past(reg_we)) |=> !irq_n);

  a_r7_no_new: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && opt_en[1] && !$past(opt_en[8])) |=> irq_n);

  a_r9_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_en[3:2] == 2'b00) |-> (swp_dout == swp_din));
endmodule

bind hostctl_reg hostctl_reg_chk #(.REV_ID(REV_ID)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_rdata(reg_rdata),
  .clr_i(clr_i), .irq_n(irq_n), .opt_en(opt_en),
  .swp_din(swp_din), .swp_dout(swp_dout)
);

// File: tb/hostctl_reg_tb.sv
module hostctl_reg_tb_top;
  localparam logic [15:0] REV = 16'h5A21;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, evt_i = 1'b0, clr_i = 1'b0;
  logic [31:0] reg_wdata = '0, swp_din = '0, reg_rdata, swp_dout;
  logic irq_n, aux_we_a, aux_we_b;
  logic [15:0] opt_en;
  int runs = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hostctl_reg #(.REV_ID(REV)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_i(evt_i), .clr_i(clr_i), .irq_n(irq_n),
    .aux_we_a(aux_we_a), .aux_we_b(aux_we_b), .opt_en(opt_en),
    .swp_din(swp_din), .swp_dout(swp_dout)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [31:0] v);
    reg_we = 1'b1; reg_wdata = v; step(); reg_we = 1'b0;
  endtask

  task automatic evt();
    evt_i = 1'b1; step(); evt_i = 1'b0;
  endtask

  task automatic clr();
    clr_i = 1'b1; step(); clr_i = 1'b0;
  endtask

  function automatic logic [31:0] swap_ref(logic [31:0] d, bit bs, bit ws);
    logic [31:0] r = d;
    if (bs) begin
      r = '0;
      for (int i = 0; i < 4; i++) r = r | (((d >> (8 * i)) & 32'hFF) << (8 * (3 - i)));
    end
    if (ws) r = (r >> 16) | (r << 16);
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state, R1 revision
    check("R2 rdata", reg_rdata, {REV, 16'h0});
    check("R2 irq_n", {31'b0, irq_n}, 32'd1);
    check("R2 we", {30'b0, aux_we_b, aux_we_a}, 32'd0);
    // R1, R3 full write
    wr(32'hFFFF_FFFF);
    check("R1 R3 all ones", reg_rdata, {REV, 16'hFFFE});
    check("R3 opt_en", {16'h0, opt_en}, 32'h0000_FFFE);
    wr(32'h0000_A5A5);
    check("R3 pattern", reg_rdata, {REV, 16'hA5A4});
    // R8 write permissions
    for (int v = 0; v < 4; v++) begin
      wr(32'(v) << 4);
      check("R8 we", {30'b0, aux_we_b, aux_we_a}, 32'(v));
    end
    // R9 swap sweep
    for (int m = 0; m < 4; m++) begin
      wr(32'(m) << 2);
      for (int k = 0; k < 8; k++) begin
        logic [31:0] d = (32'h0123_4567 * (k + 3)) ^ (32'(k) << 28) ^ 32'h8040_2010;
        swp_din = d; #1;
        check("R9 swap", swp_dout, swap_ref(d, m[0], m[1]));
      end
    end
    wr(32'h0);
    // R4 basic assertion and latency
    evt();
    check("R4 not yet", {31'b0, irq_n}, 32'd1);
    step();
    check("R4 asserted", {31'b0, irq_n}, 32'd0);
    clr();
    check("R4 clear lag", {31'b0, irq_n}, 32'd0);
    step();
    check("R4 cleared", {31'b0, irq_n}, 32'd1);
    // R4 clear wins over same-cycle event
    evt_i = 1'b1; clr_i = 1'b1; step(); evt_i = 1'b0; clr_i = 1'b0;
    step(); step();
    check("R4 clear wins", {31'b0, irq_n}, 32'd1);
    // R5 pin mask after assertion, flag retained
    evt(); step();
    wr(32'h100);
    check("R5 lag", {31'b0, irq_n}, 32'd0);
    step();
    check("R5 forced high", {31'b0, irq_n}, 32'd1);
    wr(32'h0); step();
    check("R5 restored", {31'b0, irq_n}, 32'd0);
    // R6 output mask holds an asserted pin
    wr(32'h2); step(); step();
    check("R6 held low", {31'b0, irq_n}, 32'd0);
    clr(); step();
    check("R6 clear under mask", {31'b0, irq_n}, 32'd1);
    // R7 block then replay
    evt(); step(); step();
    check("R7 blocked", {31'b0, irq_n}, 32'd1);
    wr(32'h0); step();
    check("R7 replayed", {31'b0, irq_n}, 32'd0);
    clr(); step();
    // R7 no replay once cleared
    wr(32'h2); evt(); clr(); wr(32'h0); step(); step();
    check("R7 no replay", {31'b0, irq_n}, 32'd1);
    // R5 R7 mask combination sweep before an event
    for (int c = 0; c < 4; c++) begin
      wr((c[0] ? 32'h2 : 32'h0) | (c[1] ? 32'h100 : 32'h0));
      evt(); step(); step();
      check("R5 R7 combo", {31'b0, irq_n}, (c == 0) ? 32'd0 : 32'd1);
      wr(32'h0); step();
      check("R5 R7 unmask", {31'b0, irq_n}, 32'd0);
      clr(); step();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule